// File: doc/BRIEF.md
# Trial Node Picker

During backtracking in a quasi-cyclic LDPC decoder, each trial flips the input of one candidate variable node, meaning a node next to an unsatisfied check. A tag memory records these candidates as one bit per variable node and one word per block column. This unit searches that memory for the next candidate to try. It walks block columns in an order held in a programmable table, which is normally sorted so that low-degree columns come first. It reads one tag word per cycle and picks the lowest-numbered set bit. It then writes the word back with that bit cleared, so the same node is never offered twice.

The bit selection is a two-level parallel search and does not scan the word bit by bit. The word is split into fixed-width groups. Each group computes an OR and isolates its lowest set bit. The lowest group that holds a one then supplies the final one-hot vector. The unit reports the result as a block-column index, a bit position and the one-hot vector, marked by a one-cycle strobe. When every remaining table entry points at an all-zero word, the unit raises a sticky flag that stays set until the next restart.

Top module: `trial_node_picker`

## Requirements
- R1: After reset, `found`, `exhausted`, `rd_en` and `wr_en` are all low, and the visit cursor points at table slot 0.
- R2: Within a non-zero word, the selected node is the lowest-indexed set bit. `sel_vec` has exactly that one bit set and `sel_bit` gives its index (bit 0 is the word's least significant bit).
- R3: The word is searched in groups of `GRP_W` bits (group g covers bits g*GRP_W up to g*GRP_W+GRP_W-1). When ones sit in several groups, the lowest group wins, including across a group boundary.
- R4: In the cycle a non-zero word is evaluated, the unit writes it back to the same address with only the selected bit cleared. A read and a write are never issued in the same cycle.
- R5: An all-zero word causes no write, and the unit reads the word for the next table slot in the very next cycle.
- R6: The read addresses follow the visit-order table: slot k, programmed through `cfg_slot`/`cfg_col`, supplies the block column read k-th after a restart.
- R7: `found` rises two clock edges after a `req` that hits on the current slot. Each all-zero word skipped on the way adds exactly one edge.
- R8: When the word for the last slot (`cfg_len`-1) is zero, `exhausted` is set on the edge that evaluates it. While `exhausted` is set, `req` triggers no reads, no writes and no `found`, and the flag stays set.
- R9: `restart` clears `exhausted`, abandons any search in progress and returns the cursor to slot 0.
- R10: After a hit, the cursor stays on that slot, so the next `req` rereads the same word before moving on.
- R11: With `cfg_len` equal to 0, a `req` sets `exhausted` on the next edge without any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write one entry of the visit-order table |
| cfg_slot | input | COL_W | Table slot being written |
| cfg_col | input | COL_W | Block-column index stored in that slot |
| cfg_len | input | LEN_W | Number of valid table slots |
| restart | input | 1 | Start a new candidate page: cursor to slot 0, flag cleared |
| req | input | 1 | Ask for the next candidate node |
| rd_en | output | 1 | Tag memory read strobe (data is expected one cycle later) |
| rd_addr | output | COL_W | Tag memory read address |
| rd_data | input | WORD_W | Tag word returned by the memory |
| wr_en | output | 1 | Tag memory write strobe |
| wr_addr | output | COL_W | Tag memory write address |
| wr_data | output | WORD_W | Tag word with the selected bit cleared |
| found | output | 1 | One-cycle strobe: a candidate was selected |
| sel_col | output | COL_W | Block column of the selected node |
| sel_bit | output | BIT_W | Bit position of the selected node in its word |
| sel_vec | output | WORD_W | One-hot vector of the selected node |
| exhausted | output | 1 | No candidates remain in the visit order |

## Verification
The bench aims at the group edges of the search. It uses bit pairs that straddle a group boundary and ones scattered across several groups. A priority network with the wrong group order, or a broken lowest-bit isolation, would return a higher bit or a vector with more than one bit set. It drains a word node by node and checks the tag memory contents, which catches a write-back that clears the wrong bit or skips an empty word. It also counts edges from request to strobe, so a cursor that rescans from slot 0 after a hit, or an extra pipeline stage, shows up as a latency error. It checks that the exhausted flag appears after the last slot, that it holds and stays quiet under further requests, and that restart clears it. A zero-length table must exhaust at once without touching memory.

// File: rtl/trial_node_picker.sv
module trial_node_picker #(
  parameter int WORD_W   = 96,
  parameter int GRP_W    = 12,
  parameter int MAX_COLS = 24,
  localparam int NGRP    = WORD_W / GRP_W,
  localparam int COL_W   = $clog2(MAX_COLS),
  localparam int BIT_W   = $clog2(WORD_W),
  localparam int LEN_W   = $clog2(MAX_COLS + 1),
  localparam int LOC_W   = $clog2(GRP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [COL_W-1:0]  cfg_slot,
  input  logic [COL_W-1:0]  cfg_col,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              restart,
  input  logic              req,
  output logic              rd_en,
  output logic [COL_W-1:0]  rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_en,
  output logic [COL_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              found,
  output logic [COL_W-1:0]  sel_col,
  output logic [BIT_W-1:0]  sel_bit,
  output logic [WORD_W-1:0] sel_vec,
  output logic              exhausted
);

  logic [COL_W-1:0]  order_q [MAX_COLS];
  logic [COL_W-1:0]  pos_q;
  logic              busy_q;

  logic [NGRP-1:0]   grp_any;
  logic [NGRP-1:0]   grp_pick;
  logic [GRP_W-1:0]  grp_bits [NGRP];
  logic [GRP_W-1:0]  grp_low  [NGRP];
  logic [LOC_W-1:0]  grp_idx  [NGRP];
  logic [WORD_W-1:0] pick_vec;
  logic [BIT_W-1:0]  pick_bit;
  logic              zero_n;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_bits[g] = rd_data[g*GRP_W +: GRP_W];
    assign grp_any[g]  = |grp_bits[g];
    assign grp_low[g]  = grp_bits[g] & (~grp_bits[g] + 1'b1);
    assign pick_vec[g*GRP_W +: GRP_W] = grp_pick[g] ? grp_low[g] : '0;

    always_comb begin
      grp_idx[g] = '0;
      for (int i = GRP_W - 1; i >= 0; i--)
        if (grp_bits[g][i]) grp_idx[g] = LOC_W'(i);
    end
  end

  assign grp_pick = grp_any & (~grp_any + 1'b1);
  assign zero_n   = |grp_any;

  always_comb begin
    pick_bit = '0;
    for (int g = 0; g < NGRP; g++)
      if (grp_pick[g]) pick_bit = BIT_W'(g * GRP_W) + BIT_W'(grp_idx[g]);
  end

  logic last_slot, start_ok, step, hit, drained;

  assign last_slot = (LEN_W'(pos_q) + 1'b1) >= cfg_len;
  assign start_ok  = !busy_q && req && !exhausted && !restart && (cfg_len != '0);
  assign step      = busy_q && !restart && !zero_n && !last_slot;
  assign hit       = busy_q && !restart && zero_n;
  assign drained   = busy_q && !restart && !zero_n && last_slot;

  assign rd_en   = start_ok || step;
  assign rd_addr = step ? order_q[COL_W'(pos_q + 1'b1)] : order_q[pos_q];
  assign wr_en   = hit;
  assign wr_addr = order_q[pos_q];
  assign wr_data = rd_data ^ pick_vec;

  for (genvar s = 0; s < MAX_COLS; s++) begin : g_order
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                order_q[s] <= COL_W'(s);
      else if (cfg_we && cfg_slot == COL_W'(s)) order_q[s] <= cfg_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      pos_q     <= '0;
      exhausted <= 1'b0;
      found     <= 1'b0;
      sel_col   <= '0;
      sel_bit   <= '0;
      sel_vec   <= '0;
    end else if (restart) begin
      busy_q    <= 1'b0;
      pos_q     <= '0;
      exhausted <= 1'b0;
      found     <= 1'b0;
    end else begin
      found <= hit;
      if (hit) begin
        sel_col <= order_q[pos_q];
        sel_bit <= pick_bit;
        sel_vec <= pick_vec;
        busy_q  <= 1'b0;
      end
      if (step) pos_q <= pos_q + 1'b1;
      if (drained) begin
        busy_q    <= 1'b0;
        exhausted <= 1'b1;
      end
      if (!busy_q && req && !exhausted && cfg_len == '0) exhausted <= 1'b1;
      if (start_ok) busy_q <= 1'b1;
    end
  end

endmodule

// File: rtl/trial_node_picker_chk.sv
module trial_node_picker_chk #(
  parameter int WORD_W = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              rd_en,
  input logic              wr_en,
  input logic [WORD_W-1:0] rd_data,
  input logic [WORD_W-1:0] wr_data,
  input logic              found,
  input logic [WORD_W-1:0] sel_vec,
  input logic              exhausted
);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> $countones(sel_vec) == 1);

  p_wb_one_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~rd_data) == '0) && ($countones(rd_data ^ wr_data) == 1));

  p_no_rw_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_found_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !restart |=> found);

  p_exh_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted && !restart |=> exhausted);

  p_exh_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !rd_en && !wr_en && !found);

  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !exhausted && !found);

endmodule

bind trial_node_picker trial_node_picker_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .rd_en(rd_en), .wr_en(wr_en),
  .rd_data(rd_data), .wr_data(wr_data), .found(found), .sel_vec(sel_vec),
  .exhausted(exhausted)
);

// File: tb/trial_node_picker_tb.sv
module trial_node_picker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 96;
  localparam int MAX_COLS = 24;
  localparam int COL_W = $clog2(MAX_COLS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int LEN_W = $clog2(MAX_COLS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [COL_W-1:0] cfg_slot = '0, cfg_col = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic restart = 1'b0, req = 1'b0;
  logic rd_en, wr_en, found, exhausted;
  logic [COL_W-1:0] rd_addr, wr_addr, sel_col;
  logic [WORD_W-1:0] rd_data, wr_data, sel_vec;
  logic [BIT_W-1:0] sel_bit;

  logic [WORD_W-1:0] mem [MAX_COLS];
  logic tb_we = 1'b0;
  logic [COL_W-1:0] tb_addr = '0;
  logic [WORD_W-1:0] tb_data = '0;
  logic [COL_W-1:0] rd_log [256];
  int rd_n = 0, wr_n = 0;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trial_node_picker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_col(cfg_col),
    .cfg_len(cfg_len), .restart(restart), .req(req), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .found(found), .sel_col(sel_col), .sel_bit(sel_bit), .sel_vec(sel_vec),
    .exhausted(exhausted)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      rd_log[rd_n % 256] <= rd_addr;
      rd_n <= rd_n + 1;
    end
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_n <= wr_n + 1;
    end
    if (tb_we) mem[tb_addr] <= tb_data;
  end

  task automatic chk(input bit ok, input string rq, input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", rq, what);
    end
  endtask

  function automatic logic [WORD_W-1:0] bit1(input int b);
    return WORD_W'(1) << b;
  endfunction

  task automatic load(input int a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = COL_W'(a); tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic prog(input int s, input int c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = COL_W'(s); cfg_col = COL_W'(c);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic do_req(output int k, output bit f, output bit x);
    @(negedge clk);
    req = 1'b1;
    k = 0; f = 1'b0; x = 1'b0;
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      req = 1'b0;
      if (found || exhausted) begin
        k = i; f = found; x = exhausted;
        break;
      end
    end
  endtask

  task automatic expect_hit(input string rq, input int col, input int b, input int lat);
    int k; bit f, x;
    do_req(k, f, x);
    chk(f && int'(sel_col) == col && int'(sel_bit) == b && sel_vec == bit1(b), rq,
        $sformatf("found=%0b col=%0d bit=%0d vec=%h expected col=%0d bit=%0d", f, sel_col, sel_bit, sel_vec, col, b));
    chk(k == lat, "R7", $sformatf("latency %0d expected %0d", k, lat));
  endtask

  task automatic t_reset();
    chk(!found && !exhausted && !rd_en && !wr_en, "R1",
        $sformatf("found=%0b exh=%0b rd=%0b wr=%0b expected all 0", found, exhausted, rd_en, wr_en));
  endtask

  task automatic t_drain_word();
    load(5, bit1(17) | bit1(40) | bit1(90));
    do_restart();
    expect_hit("R2", 5, 17, 2);
    chk(mem[5] == (bit1(40) | bit1(90)), "R4", $sformatf("mem5=%h expected %h", mem[5], bit1(40) | bit1(90)));
    expect_hit("R2", 5, 40, 2);
    expect_hit("R3", 5, 90, 2);
    chk(mem[5] == '0, "R4", $sformatf("mem5=%h expected 0", mem[5]));
  endtask

  task automatic t_skip_and_order();
    int r0, w0;
    load(9, bit1(95) | bit1(12) | bit1(11));
    r0 = rd_n; w0 = wr_n;
    expect_hit("R5", 9, 11, 4);
    chk(rd_n - r0 == 3 && rd_log[r0 % 256] == 5 && rd_log[(r0+1) % 256] == 2 && rd_log[(r0+2) % 256] == 9, "R6",
        $sformatf("reads=%0d seq %0d,%0d,%0d expected 3 reads 5,2,9", rd_n - r0,
                  rd_log[r0 % 256], rd_log[(r0+1) % 256], rd_log[(r0+2) % 256]));
    chk(wr_n - w0 == 1, "R5", $sformatf("writes=%0d expected 1", wr_n - w0));
    expect_hit("R10", 9, 12, 2);
    expect_hit("R3", 9, 95, 2);
  endtask

  task automatic t_group_edge();
    load(0, bit1(24) | bit1(23));
    expect_hit("R3", 0, 23, 3);
    expect_hit("R3", 0, 24, 2);
  endtask

  task automatic t_exhaust();
    int k, r0, w0; bit f, x;
    do_restart();
    do_req(k, f, x);
    chk(x && !f && k == 5, "R8", $sformatf("exh=%0b found=%0b at %0d expected exh at 5", x, f, k));
    r0 = rd_n; w0 = wr_n;
    do_req(k, f, x);
    repeat (3) @(negedge clk);
    chk(exhausted && !found && rd_n == r0 && wr_n == w0, "R8",
        $sformatf("exh=%0b found=%0b reads=%0d writes=%0d expected 1,0,0,0", exhausted, found, rd_n - r0, wr_n - w0));
  endtask

  task automatic t_restart();
    load(2, bit1(5));
    do_restart();
    chk(!exhausted, "R9", $sformatf("exh=%0b expected 0", exhausted));
    expect_hit("R9", 2, 5, 3);
  endtask

  task automatic t_zero_len();
    int k, r0; bit f, x;
    cfg_len = '0;
    do_restart();
    r0 = rd_n;
    do_req(k, f, x);
    chk(x && k == 1 && rd_n == r0, "R11", $sformatf("exh=%0b at %0d reads=%0d expected exh at 1, 0 reads", x, k, rd_n - r0));
  endtask

  initial begin
    for (int i = 0; i < MAX_COLS; i++) mem[i] = '0;
    rd_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    prog(0, 5); prog(1, 2); prog(2, 9); prog(3, 0);
    cfg_len = LEN_W'(4);
    t_drain_word();
    t_skip_and_order();
    t_group_edge();
    t_exhaust();
    t_restart();
    t_zero_len();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule